// File: doc/BRIEF.md
# Prioritized Four-Input Interrupt Controller

The block gathers interrupt requests from four external pins and from messages posted over the data bus. It keeps each one pending and offers the core the single most urgent request that outranks the current processor priority. The offer is a request flag with an 8-bit vector. When the core acknowledges the offer, only the source that was offered is cleared, and the next eligible request takes its place.

Each pin has its own programmable 5-bit priority and 8-bit vector. A bus message carries its own priority and vector. The block can also run in an expansion mode for systems with more interrupt sources. In that mode pin 2 carries the request line of an external cascaded controller. Pin 3 is no longer an input, and its acknowledge role is served by the `cas_ack_o` output. The block runs a two-pulse acknowledge sequence on that output and takes the vector from the external controller's data lines during the second pulse.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with nothing pending, `int_req_o` and `cas_ack_o` are low.
- R2: A pin that goes from low to high becomes pending. When it is eligible, `int_req_o` is high with the pin's vector on the fourth rising clock edge after the pin is first sampled high. Pin i uses `pin_prio_i[5i+4:5i]` and `pin_vec_i[8i+7:8i]`.
- R3: A pending source is offered only when its priority is strictly greater than `cur_prio_i`. Equal priority holds the source off.
- R4: The block re-evaluates held-off pending sources on every clock edge. Once `cur_prio_i` drops below a source's priority, that source is offered on the next rising edge.
- R5: The highest eligible priority wins. When priorities tie, the lower-numbered pin wins, and a bus message loses to any pin of equal priority.
- R6: When `int_ack_i` is high while `int_req_o` is high, the offered source is cleared, and the next eligible source is offered on that same edge.
- R7: A one-cycle `msg_valid_i` posts a request that carries `msg_prio_i` and `msg_vec_i`, and it is offered on the second edge. Messages that arrive while a message is pending are ignored.
- R8: A pin that stays high after its request has been acknowledged does not post again. It must go low and then high again.
- R9: In expansion mode (`xmode_i`=1), a new request on pin 2 drives `cas_ack_o` high for two single-cycle pulses separated by one low cycle. The first pulse appears on the fourth edge after pin 2 is first sampled high.
- R10: In expansion mode, the pin-2 request is offered with the `cas_vec_i` value sampled at the end of the second pulse, not the first, and it is ranked by pin 2's priority.
- R11: In expansion mode, the pin-3 input is ignored and never produces a request.
- R12: Outside expansion mode, `cas_ack_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 4 | Asynchronous interrupt pins |
| pin_prio_i | input | 20 | Per-pin priority, 5 bits per pin |
| pin_vec_i | input | 32 | Per-pin vector, 8 bits per pin |
| msg_valid_i | input | 1 | Bus interrupt message strobe |
| msg_prio_i | input | 5 | Priority of the bus message |
| msg_vec_i | input | 8 | Vector of the bus message |
| cur_prio_i | input | 5 | Current processor priority |
| xmode_i | input | 1 | Expansion mode select |
| cas_vec_i | input | 8 | Vector driven by the cascaded controller |
| cas_ack_o | output | 1 | Acknowledge pulses to the cascaded controller |
| int_req_o | output | 1 | Interrupt offered to the core |
| int_vec_o | output | 8 | Vector of the offered interrupt |
| int_ack_i | input | 1 | Core acknowledge of the offered interrupt |

## Verification
A pending bit that is stuck or lost shows up at the ports within a few cycles. It either appears as an extra vector in the acknowledge sequence that the scoreboard compares, or as a missing one. A mistake in the arbitration order reorders that sequence at the first acknowledge. Errors in the cascade state machine show up directly on `cas_ack_o`, where every edge of the pulse train is checked. A wrong capture point shows up as the first-pulse bus value appearing on `int_vec_o`, because the bench changes the bus value between the two pulses.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_P1,
    CS_GAP,
    CS_P2,
    CS_READY
  } cas_state_e;
endpackage

// File: rtl/pic_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer per pin plus a third stage for rise detection.
module pic_sync #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
        s3_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= async_i[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end
    assign rise_o[g] = s2_q[g] & ~s3_q[g];
  end
endmodule

// File: rtl/pic_arb.sv
`timescale 1ns/1ps
// Picks the highest eligible priority; ties go to the lower index.
module pic_arb #(
  parameter int NSRC   = 5,
  parameter int PRIO_W = 5,
  parameter int VEC_W  = 8,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        valid_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [NSRC*VEC_W-1:0]  vec_i,
  input  logic [PRIO_W-1:0]      cur_prio_i,
  output logic                   hit_o,
  output logic [SEL_W-1:0]       sel_o,
  output logic [VEC_W-1:0]       vec_o
);
  logic [PRIO_W-1:0] best;
  logic [PRIO_W-1:0] p;

  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    best  = '0;
    p     = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      p = prio_i[i*PRIO_W +: PRIO_W];
      if (valid_i[i] && (p > cur_prio_i) && (!hit_o || p >= best)) begin
        hit_o = 1'b1;
        sel_o = SEL_W'(i);
        best  = p;
      end
    end
    vec_o = vec_i[sel_o*VEC_W +: VEC_W];
  end
endmodule

// File: rtl/pic_cascade.sv
`timescale 1ns/1ps
// Two-pulse acknowledge sequence toward an external cascaded controller.
module pic_cascade
  import pic_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic             clr_i,
  input  logic [VEC_W-1:0] bus_vec_i,
  output logic             ack_o,
  output logic             ready_o,
  output logic [VEC_W-1:0] vec_o
);
  cas_state_e       state_q, state_d;
  logic [VEC_W-1:0] vec_q;
  logic             cap_en;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = CS_IDLE;
    end else begin
      case (state_q)
        CS_IDLE:  if (req_i && !clr_i) state_d = CS_P1;
        CS_P1:    state_d = CS_GAP;
        CS_GAP:   state_d = CS_P2;
        CS_P2:    state_d = CS_READY;
        CS_READY: if (clr_i) state_d = CS_IDLE;
        default:  state_d = CS_IDLE;
      endcase
    end
  end

  assign cap_en = en_i && (state_q == CS_P2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_IDLE;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) vec_q <= bus_vec_i;
    end
  end

  assign ack_o   = (state_q == CS_P1) || (state_q == CS_P2);
  assign ready_o = (state_q == CS_READY);
  assign vec_o   = vec_q;

  // R9
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R10
  capture_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(ack_o));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int NPIN    = 4,
  parameter int PRIO_W  = 5,
  parameter int VEC_W   = 8,
  parameter int CAS_REQ = 2,
  parameter int CAS_ACK = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NPIN-1:0]        irq_pin_i,
  input  logic [NPIN*PRIO_W-1:0] pin_prio_i,
  input  logic [NPIN*VEC_W-1:0]  pin_vec_i,
  input  logic                   msg_valid_i,
  input  logic [PRIO_W-1:0]      msg_prio_i,
  input  logic [VEC_W-1:0]       msg_vec_i,
  input  logic [PRIO_W-1:0]      cur_prio_i,
  input  logic                   xmode_i,
  input  logic [VEC_W-1:0]       cas_vec_i,
  output logic                   cas_ack_o,
  output logic                   int_req_o,
  output logic [VEC_W-1:0]       int_vec_o,
  input  logic                   int_ack_i
);
  localparam int NSRC   = NPIN + 1;
  localparam int MSG_ID = NPIN;
  localparam int SEL_W  = $clog2(NSRC);

  logic [NPIN-1:0]        rise;
  logic [NPIN-1:0]        pend_q, pend_d, pin_mask;
  logic                   msg_pend_q, msg_pend_d, msg_take;
  logic [PRIO_W-1:0]      msg_prio_q;
  logic [VEC_W-1:0]       msg_vec_q;
  logic [NSRC-1:0]        clr, src_valid;
  logic [NSRC*PRIO_W-1:0] src_prio;
  logic [NSRC*VEC_W-1:0]  src_vec;
  logic                   req_q, arb_hit;
  logic [SEL_W-1:0]       src_q, arb_sel;
  logic [VEC_W-1:0]       vec_q, arb_vec;
  logic                   cas_ready;
  logic [VEC_W-1:0]       cas_vec;

  pic_sync #(.N(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_pin_i),
    .rise_o (rise)
  );

  // one-hot clear of the source the core accepts this cycle
  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    assign clr[g] = int_ack_i && req_q && (src_q == SEL_W'(g));
  end

  // pin sources: pending state, eligibility and table entries
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    if (g == CAS_REQ) begin : g_creq
      assign pin_mask[g]                  = 1'b1;
      assign src_valid[g]                 = pend_q[g] && !clr[g] && (!xmode_i || cas_ready);
      assign src_vec[g*VEC_W +: VEC_W]    = xmode_i ? cas_vec : pin_vec_i[g*VEC_W +: VEC_W];
    end else if (g == CAS_ACK) begin : g_cack
      assign pin_mask[g]                  = !xmode_i;
      assign src_valid[g]                 = pend_q[g] && !clr[g] && !xmode_i;
      assign src_vec[g*VEC_W +: VEC_W]    = pin_vec_i[g*VEC_W +: VEC_W];
    end else begin : g_plain
      assign pin_mask[g]                  = 1'b1;
      assign src_valid[g]                 = pend_q[g] && !clr[g];
      assign src_vec[g*VEC_W +: VEC_W]    = pin_vec_i[g*VEC_W +: VEC_W];
    end
    assign src_prio[g*PRIO_W +: PRIO_W] = pin_prio_i[g*PRIO_W +: PRIO_W];
  end

  assign src_valid[MSG_ID]                 = msg_pend_q && !clr[MSG_ID];
  assign src_prio[MSG_ID*PRIO_W +: PRIO_W] = msg_prio_q;
  assign src_vec[MSG_ID*VEC_W +: VEC_W]    = msg_vec_q;

  always_comb begin
    pend_d     = ((pend_q & ~clr[NPIN-1:0]) | rise) & pin_mask;
    msg_take   = msg_valid_i && !msg_pend_q;
    msg_pend_d = msg_take || (msg_pend_q && !clr[MSG_ID]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      msg_pend_q <= 1'b0;
      msg_prio_q <= '0;
      msg_vec_q  <= '0;
    end else begin
      pend_q     <= pend_d;
      msg_pend_q <= msg_pend_d;
      if (msg_take) begin
        msg_prio_q <= msg_prio_i;
        msg_vec_q  <= msg_vec_i;
      end
    end
  end

  pic_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
    .valid_i   (src_valid),
    .prio_i    (src_prio),
    .vec_i     (src_vec),
    .cur_prio_i(cur_prio_i),
    .hit_o     (arb_hit),
    .sel_o     (arb_sel),
    .vec_o     (arb_vec)
  );

  pic_cascade #(.VEC_W(VEC_W)) u_cas (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (xmode_i),
    .req_i    (pend_q[CAS_REQ]),
    .clr_i    (clr[CAS_REQ]),
    .bus_vec_i(cas_vec_i),
    .ack_o    (cas_ack_o),
    .ready_o  (cas_ready),
    .vec_o    (cas_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      src_q <= '0;
      vec_q <= '0;
    end else begin
      req_q <= arb_hit;
      src_q <= arb_sel;
      vec_q <= arb_vec;
    end
  end

  assign int_req_o = req_q;
  assign int_vec_o = vec_q;

  // R6
  ack_retires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ack_i && int_req_o) |=> !(int_req_o && (src_q == $past(src_q))));

  // R3
  top_prio_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_prio_i == '1) |=> !int_req_o);

  // R11
  ack_pin_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xmode_i && $past(xmode_i)) |-> !(int_req_o && (src_q == SEL_W'(CAS_ACK))));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  pins;
  logic [19:0] pprio;
  logic [31:0] pvec;
  logic        msg_v;
  logic [4:0]  msg_p;
  logic [7:0]  msg_vec;
  logic [4:0]  cur;
  logic        xmode;
  logic [7:0]  cas_vec;
  logic        cas_ack;
  logic        req;
  logic [7:0]  vec;
  logic        ack_sb, ack_man;
  logic        sb_on;
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0;
  int          cas_phase = 0;
  int          r12_bad = 0;
  logic [7:0]  expq[$];

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pins), .pin_prio_i(pprio),
    .pin_vec_i(pvec), .msg_valid_i(msg_v), .msg_prio_i(msg_p), .msg_vec_i(msg_vec),
    .cur_prio_i(cur), .xmode_i(xmode), .cas_vec_i(cas_vec), .cas_ack_o(cas_ack),
    .int_req_o(req), .int_vec_o(vec), .int_ack_i(ack_sb | ack_man)
  );

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_req(string tag, logic r, logic [7:0] v);
    chk({tag, " req"}, {7'd0, req}, {7'd0, r});
    if (r) chk({tag, " vec"}, vec, v);
  endtask

  task automatic ack_once();
    ack_man = 1'b1;
    tick();
    ack_man = 1'b0;
  endtask

  // scoreboard monitor: pops expected vectors and acknowledges each offer
  always @(negedge clk) begin
    ack_sb = 1'b0;
    if (sb_on && req) begin
      if (expq.size() == 0) begin
        chk("R5 unexpected offer", vec, 8'hxx);
      end else begin
        chk("R5/R6 order", vec, expq.pop_front());
      end
      ack_sb = 1'b1;
    end
  end

  // cascaded controller model: changes its bus value between the two pulses
  always @(negedge clk) begin
    if (!xmode && cas_ack) r12_bad++;
    if (cas_phase == 0 && cas_ack) cas_phase = 1;
    else if (cas_phase == 1 && !cas_ack) begin
      cas_vec   = 8'hAA;
      cas_phase = 2;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins = 4'h0; msg_v = 1'b0; msg_p = '0; msg_vec = '0;
    cur = '0; xmode = 1'b0; cas_vec = 8'h55; ack_man = 1'b0; sb_on = 1'b0; ack_sb = 1'b0;
    // pin3: prio 3 vec 13, pin2: 9/12, pin1: 9/11, pin0: 5/10
    pprio = {5'd3, 5'd9, 5'd9, 5'd5};
    pvec  = {8'h13, 8'h12, 8'h11, 8'h10};
    tick(3);
    chk_req("R1 in reset", 1'b0, 8'h00);
    chk("R1 cas in reset", {7'd0, cas_ack}, 8'h00);
    rst_n = 1'b1;
    tick(2);
    chk_req("R1 after reset", 1'b0, 8'h00);

    // R2 latency
    pins[1] = 1'b1;
    tick(3);
    chk_req("R2 before 4th edge", 1'b0, 8'h00);
    tick();
    chk_req("R2 offered", 1'b1, 8'h11);
    ack_once();
    chk_req("R6 cleared", 1'b0, 8'h00);
    tick(6);
    chk_req("R8 held level no repost", 1'b0, 8'h00);

    // R3 / R4
    cur = 5'd9;
    pins[2] = 1'b1;
    tick(6);
    chk_req("R3 equal prio held", 1'b0, 8'h00);
    cur = 5'd8;
    tick();
    chk_req("R4 offered after drop", 1'b1, 8'h12);
    ack_once();
    cur = 5'd0;

    // R5 ordering with scoreboard
    pins = 4'h0;
    tick(5);
    pins = 4'hF;
    msg_v = 1'b1; msg_p = 5'd9; msg_vec = 8'h20;
    tick();
    msg_v = 1'b0;
    tick(6);
    expq.push_back(8'h11); expq.push_back(8'h12); expq.push_back(8'h20);
    expq.push_back(8'h10); expq.push_back(8'h13);
    sb_on = 1'b1;
    for (int w = 0; w < 50 && expq.size() != 0; w++) tick();
    tick();
    sb_on = 1'b0;
    chk("R5 queue drained", 8'(expq.size()), 8'h00);
    tick(3);
    chk_req("R6 all served", 1'b0, 8'h00);

    // R7 message, second ignored while pending
    cur = 5'd31;
    msg_v = 1'b1; msg_p = 5'd4; msg_vec = 8'h30;
    tick();
    msg_p = 5'd20; msg_vec = 8'h31;
    tick();
    msg_v = 1'b0;
    tick(3);
    chk_req("R3 top prio blocks", 1'b0, 8'h00);
    cur = 5'd0;
    tick();
    chk_req("R7 first message", 1'b1, 8'h30);
    ack_once();
    tick(3);
    chk_req("R7 second message ignored", 1'b0, 8'h00);

    // expansion mode
    pins = 4'h0;
    tick(5);
    xmode = 1'b1;
    tick();
    pins[3] = 1'b1;
    tick(8);
    chk_req("R11 pin3 ignored", 1'b0, 8'h00);
    chk("R11 no cas pulse", {7'd0, cas_ack}, 8'h00);
    cur = 5'd9;
    pins[2] = 1'b1;
    tick(3);
    chk("R9 no pulse yet", {7'd0, cas_ack}, 8'h00);
    tick();
    chk("R9 pulse 1", {7'd0, cas_ack}, 8'h01);
    tick();
    chk("R9 gap", {7'd0, cas_ack}, 8'h00);
    tick();
    chk("R9 pulse 2", {7'd0, cas_ack}, 8'h01);
    tick();
    chk("R9 end", {7'd0, cas_ack}, 8'h00);
    tick();
    chk_req("R10 ranked by pin2 prio", 1'b0, 8'h00);
    cur = 5'd8;
    tick();
    chk_req("R10 second-pulse vector", 1'b1, 8'hAA);
    ack_once();
    tick(4);
    chk_req("R11 pin3 still ignored", 1'b0, 8'h00);
    chk("R9 no extra pulse", {7'd0, cas_ack}, 8'h00);

    chk("R12 cas low outside xmode", 8'(r12_bad), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule